// File: doc/BRIEF.md
# IR Pulse Run-Length Sampler

This block turns the output of an infrared demodulator into a stream of run-length symbols. The pin is first brought into the clock domain and optionally inverted. It is then sampled once every 64 clock cycles by a prescaler strobe. A noise filter passes a change of level only after it has been seen on enough consecutive samples. A run counter measures how long each filtered level lasts and emits one byte for each finished run.

A long stretch of space, meaning filtered level 0, ends a packet. Once the space has lasted the programmed idle timeout, the block flushes the pending run and pulses `pkt_end`. It then stays quiet until the line carries a pulse again. Downstream logic stores the bytes and uses `pkt_end` to start decoding. Holding the controls in any state other than fully enabled clears all state.

Top module: `ir_runlen_sampler`

## Requirements
- R1: Sampling runs only while `glob_en` and `rx_en` are both 1 and `mode` is 2'b11. In any other state, all run, filter and idle state is cleared, and from the next cycle on `sym_valid` and `pkt_end` stay 0. Each sample is taken once per 64 clock cycles.
- R2: When the filtered level changes, the finished run is emitted as a byte. Bit 7 holds the level of the run (1 = pulse). Bits 6:0 hold the run length in samples minus one. `sym_valid` is high for exactly one cycle with the byte.
- R3: A run longer than 128 samples is split. Each full 128 samples yields a byte with length code 0x7F, and counting of the same level continues in a new byte.
- R4: With noise threshold N (0 is treated as 1), a level change that lasts fewer than N samples is ignored and counted into the surrounding run. A change that lasts N or more samples is accepted. Both edges are delayed by the same N-1 samples, so accepted run lengths are preserved.
- R5: Filtered space that has lasted (`idle_thr`+1)×128 samples flushes the pending space run as a byte, which is always 0x7F. `pkt_end` is then high for one cycle, in the cycle after that byte.
- R6: After a packet end, and after enable, no byte is emitted until a pulse level is accepted. The first byte after that is a pulse byte.
- R7: With `rx_invert` = 1, pin level 0 is treated as pulse (level 1) and pin level 1 as space.
- R8: During reset, `sym_valid`, `pkt_end` and `sym_data` are 0.
- R9: `sym_valid` and `pkt_end` are never high in the same cycle, and `sym_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw demodulator pin, asynchronous |
| rx_invert | input | 1 | Invert the pin before sampling |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode; 2'b11 selects run-length sampling |
| noise_thr | input | 6 | Minimum accepted run, in samples |
| idle_thr | input | 8 | Idle timeout, in units of 128 samples, minus one |
| sym_data | output | 8 | Run-length byte: level in bit 7, length-1 in bits 6:0 |
| sym_valid | output | 1 | One-cycle strobe qualifying `sym_data` |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
A run counter that is off by one shows up in the very next byte as a wrong length code, no later than the next accepted level change. A filter that accepts too early or too late shows up at the edges of a pulse that is exactly N or N-1 samples long. An idle counter or waiting flag in the wrong state shows up in one of two ways: as a missing or early `pkt_end`, which appears within (`idle_thr`+1)×128 samples, or as bytes emitted during space that should be silent. A wrong split point shows up on the first run longer than 128 samples.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    localparam logic [1:0] MODE_CIR = 2'b11;

    function automatic logic rx_active(input logic g, input logic r, input logic [1:0] m);
        return g && r && (m == MODE_CIR);
    endfunction
endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q[i] <= 1'b0;
                else if (i == 0) sh_q[i] <= d;
                else sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ir_rl_tick.sv
module ir_rl_tick #(
    parameter int PRESC_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else cnt_q <= cnt_d;
    end

    assign tick = run && (&cnt_q);
endmodule

// File: rtl/ir_rl_deglitch.sv
module ir_rl_deglitch #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          din,
    input  logic [CW-1:0] thr,
    output logic          lvl_o,
    output logic          lvl_nx_o
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] n;
    } flt_t;

    flt_t s_d, s_q;
    logic [CW:0] thr_eff;
    logic [CW:0] n_inc;

    always_comb begin
        thr_eff = (thr == '0) ? (CW+1)'(1) : {1'b0, thr};
        n_inc   = {1'b0, s_q.n} + 1'b1;
        s_d     = s_q;
        if (!run) begin
            s_d = '0;
        end else if (tick) begin
            if (din == s_q.lvl) begin
                s_d.n = '0;
            end else if (n_inc >= thr_eff) begin
                s_d.lvl = din;
                s_d.n   = '0;
            end else begin
                s_d.n = n_inc[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else s_q <= s_d;
    end

    assign lvl_o    = s_q.lvl;
    assign lvl_nx_o = s_d.lvl;
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int PRESC_W     = 6,
    parameter int LEN_W       = 7,
    parameter int NOISE_W     = 6,
    parameter int IDLE_W      = 8,
    parameter int IDLE_UNIT_W = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_in,
    input  logic               rx_invert,
    input  logic               glob_en,
    input  logic               rx_en,
    input  logic [1:0]         mode,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    output logic [LEN_W:0]     sym_data,
    output logic               sym_valid,
    output logic               pkt_end
);
    localparam int SYM_W = LEN_W + 1;
    localparam int IC_W  = IDLE_W + IDLE_UNIT_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic             waiting;
        logic [LEN_W-1:0] run_len;
        logic [IC_W-1:0]  idle_cnt;
        logic             pend;
        logic [SYM_W-1:0] sym;
        logic             vld;
        logic             pkt;
    } st_t;

    localparam st_t ST_RST = '{waiting: 1'b1, default: '0};

    logic active, tick, pin_s, samp, lvl, f;
    logic [IC_W-1:0] idle_lim, idle_nx;
    st_t st_d, st_q;

    assign active = rx_active(glob_en, rx_en, mode);

    ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ir_in), .q(pin_s)
    );

    ir_rl_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
    );

    assign samp = pin_s ^ rx_invert;

    ir_rl_deglitch #(.CW(NOISE_W)) u_flt (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(tick), .din(samp),
        .thr(noise_thr), .lvl_o(lvl), .lvl_nx_o(f)
    );

    always_comb begin
        idle_lim = (IC_W'(idle_thr) + 1'b1) << IDLE_UNIT_W;
        idle_nx  = st_q.idle_cnt + 1'b1;
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.pkt  = st_q.pend;
        st_d.pend = 1'b0;
        if (!active) begin
            st_d = ST_RST;
        end else if (tick) begin
            if (st_q.waiting) begin
                if (f) begin
                    st_d.waiting  = 1'b0;
                    st_d.run_len  = '0;
                    st_d.idle_cnt = '0;
                end
            end else if (f != lvl) begin
                st_d.sym      = {lvl, st_q.run_len};
                st_d.vld      = 1'b1;
                st_d.run_len  = '0;
                st_d.idle_cnt = f ? '0 : IC_W'(1);
            end else if (!f && (idle_nx == idle_lim)) begin
                st_d.sym      = {1'b0, st_q.run_len + 1'b1};
                st_d.vld      = 1'b1;
                st_d.waiting  = 1'b1;
                st_d.pend     = 1'b1;
                st_d.run_len  = '0;
                st_d.idle_cnt = '0;
            end else begin
                if (st_q.run_len == LEN_MAX) begin
                    st_d.sym     = {lvl, LEN_MAX};
                    st_d.vld     = 1'b1;
                    st_d.run_len = '0;
                end else begin
                    st_d.run_len = st_q.run_len + 1'b1;
                end
                if (!f) st_d.idle_cnt = idle_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else st_q <= st_d;
    end

    assign sym_data  = st_q.sym;
    assign sym_valid = st_q.vld;
    assign pkt_end   = st_q.pkt;
endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker
    import ir_rl_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         glob_en,
    input logic         rx_en,
    input logic [1:0]   mode,
    input logic [LEN_W:0] sym_data,
    input logic         sym_valid,
    input logic         pkt_end
);
    logic after_pkt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) after_pkt_q <= 1'b0;
        else if (pkt_end) after_pkt_q <= 1'b1;
        else if (sym_valid) after_pkt_q <= 1'b0;
    end

    a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(glob_en && rx_en && mode == MODE_CIR) |=> !sym_valid && !pkt_end);

    a_r5_pkt_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> $past(sym_valid) && $past(sym_data) == {1'b0, {LEN_W{1'b1}}});

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> !sym_valid);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    a_r6_pulse_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && after_pkt_q) |-> sym_data[LEN_W]);
endmodule

bind ir_runlen_sampler ir_rl_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .rx_en(rx_en), .mode(mode),
    .sym_data(sym_data), .sym_valid(sym_valid), .pkt_end(pkt_end)
);

// File: tb/ir_runlen_sampler_test.sv
module ir_runlen_sampler_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b0, rx_invert = 1'b0, glob_en = 1'b0, rx_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd0;
    logic [7:0] sym_data;
    logic sym_valid, pkt_end;

    int checks = 0, errs = 0, cap_n = 0, pkt_n = 0, bad_gap = 0;
    logic [7:0] cap [64];
    logic prev_vld = 1'b0;
    logic done = 1'b0;

    localparam int VEC [5][4] = '{
        '{5,   10,  'h84, 'h09},
        '{1,   3,   'h80, 'h02},
        '{40,  2,   'hA7, 'h01},
        '{128, 7,   'hFF, 'h06},
        '{64,  100, 'hBF, 'h63}
    };

    always #2 clk = ~clk;

    ir_runlen_sampler uut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .rx_invert(rx_invert),
        .glob_en(glob_en), .rx_en(rx_en), .mode(mode), .noise_thr(noise_thr),
        .idle_thr(idle_thr), .sym_data(sym_data), .sym_valid(sym_valid),
        .pkt_end(pkt_end)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (sym_valid) begin
                if (cap_n < 64) cap[cap_n] = sym_data;
                cap_n++;
            end
            if (pkt_end) begin
                pkt_n++;
                if (!prev_vld) bad_gap++;
            end
            prev_vld = sym_valid;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic exp_sym(input string req, input int idx, input int code);
        chk(req, (idx < cap_n && idx < 64) ? int'(cap[idx]) : -1, code);
    endtask

    task automatic hold(input logic lv, input int ns);
        ir_in = lv;
        repeat (ns * 64) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R8 sym_valid in reset", sym_valid, 0);
        chk("R8 pkt_end in reset", pkt_end, 0);
        chk("R8 sym_data in reset", sym_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        glob_en = 1'b1; rx_en = 1'b1; mode = 2'b11;

        // R6: quiet space after enable produces nothing
        hold(1'b0, 20);
        chk("R6 no bytes while idle after enable", cap_n, 0);

        // R2 R3: table walk
        for (int v = 0; v < 5; v++) begin
            hold(1'b1, VEC[v][0]);
            hold(1'b0, VEC[v][1]);
        end
        hold(1'b1, 4);
        hold(1'b0, 140);
        for (int v = 0; v < 5; v++) begin
            exp_sym("R2 pulse byte", 2*v, VEC[v][2]);
            exp_sym("R2 space byte", 2*v+1, VEC[v][3]);
        end
        exp_sym("R2 short pulse", 10, 'h83);
        exp_sym("R5 flush byte", 11, 'h7F);
        chk("R5 packet count", pkt_n, 1);
        chk("R5 pkt_end right after flush", bad_gap, 0);
        hold(1'b0, 20);
        chk("R6 silent after packet end", cap_n, 12);

        // R3 split, R5 with longer timeout
        idle_thr = 8'd1;
        hold(1'b1, 200);
        hold(1'b0, 270);
        exp_sym("R3 first 128 chunk", 12, 'hFF);
        exp_sym("R3 remainder", 13, 'hC7);
        exp_sym("R3 space split", 14, 'h7F);
        exp_sym("R5 flush at 256", 15, 'h7F);
        chk("R5 packet count thr1", pkt_n, 2);

        // R4 noise filter
        idle_thr = 8'd0;
        noise_thr = 6'd3;
        hold(1'b1, 2);
        hold(1'b0, 20);
        chk("R4 idle glitch ignored", cap_n, 16);
        hold(1'b1, 10);
        hold(1'b0, 2);
        hold(1'b1, 10);
        hold(1'b0, 20);
        hold(1'b1, 3);
        hold(1'b0, 140);
        exp_sym("R4 dip absorbed", 16, 'h95);
        exp_sym("R4 space length kept", 17, 'h13);
        exp_sym("R4 run of exactly N kept", 18, 'h82);
        exp_sym("R5 flush after filtered", 19, 'h7F);
        chk("R5 packet count noise", pkt_n, 3);
        noise_thr = 6'd1;

        // R7 inversion
        rx_invert = 1'b1;
        hold(1'b1, 5);
        hold(1'b0, 7);
        hold(1'b1, 130);
        exp_sym("R7 inverted pulse", 20, 'h86);
        exp_sym("R7 flush", 21, 'h7F);
        chk("R7 packet count", pkt_n, 4);

        // R1 gating
        mode = 2'b01;
        hold(1'b0, 5);
        hold(1'b1, 10);
        chk("R1 wrong mode silent", cap_n, 22);
        mode = 2'b11; glob_en = 1'b0;
        hold(1'b0, 5);
        hold(1'b1, 10);
        chk("R1 global off silent", cap_n, 22);
        glob_en = 1'b1;
        hold(1'b0, 10);
        rx_en = 1'b0;
        hold(1'b1, 5);
        rx_en = 1'b1;
        hold(1'b1, 140);
        chk("R1 aborted run discarded", cap_n, 22);
        chk("R1 no packet end after abort", pkt_n, 4);
        hold(1'b0, 5);
        hold(1'b1, 140);
        exp_sym("R1 resumes after enable", 22, 'h84);
        exp_sym("R5 flush after resume", 23, 'h7F);
        chk("R9 pkt_end never without preceding byte", bad_gap, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule